// File: doc/BRIEF.md
# Streaming Insertion Sort Array

This block keeps a list of up to SIZE words in ascending order while unsorted words arrive, one per clock. It is built from a chain of identical compare-and-hold slots. On every insert, each slot looks at its own word and at the slot just below it. From that it decides, within the same cycle, whether to keep its word, take the new word, or take the word its lower neighbour is giving up. Every insertion therefore completes in one clock. When the last word has gone in, the list is already sorted.

Read-out uses a shift-up strobe. Each shift moves every word one slot toward the head, so the words appear in ascending order at the head port, one per clock. A list of any length from 1 to SIZE words is sorted. Per-slot occupancy flags and a full flag show how many slots hold data.

Top module: `isort_array`

## Requirements
- R1: After reset every slot is empty: `slot_valid` is all zeros, `head_valid` is 0 and `full` is 0.
- R2: An insert into an array holding k < SIZE words leaves k+1 words. Occupancy is always contiguous from the head: bit i of `slot_valid` is slot i, and bit 0 is the head slot.
- R3: After every insert the held words are in non-decreasing order from the head, so `head_word` is the smallest word held.
- R4: The comparison is strict, so a new word equal to a held word is placed after it. Inserting 5, 3, 6, 3 gives the read-out order 3, 3, 5, 6.
- R5: An insert takes effect at the next rising edge. Read-out may begin in the cycle right after the last insert.
- R6: A shift-up moves every word one slot toward the head and empties the last slot, so the next-smallest word appears at `head_word`. A shift-up on an empty array leaves it empty.
- R7: When `ins_valid` and `shift_up` are both high, the shift-up is performed and the insert is dropped.
- R8: `full` is high exactly when all SIZE slots are occupied. An insert into a full array keeps the SIZE smallest of the held words plus the new word, and drops the largest.
- R9: For any count of words from 1 to SIZE, the read-out yields exactly those words in order. After that, `head_valid` falls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert `ins_word` this cycle |
| ins_word | input | DATA_WIDTH | Unsorted word to insert |
| shift_up | input | 1 | Move the list one slot toward the head |
| head_word | output | DATA_WIDTH | Word held in the head slot |
| head_valid | output | 1 | Head slot is occupied |
| slot_valid | output | SIZE | Occupancy of each slot, bit 0 = head |
| full | output | 1 | All slots occupied |

## Verification
The assertions check several properties on every cycle: that occupancy stays contiguous from the head, that each adjacent pair of occupied slots stays in order, and that each insert or shift changes the occupied count by exactly one. They also check that a word entering an empty array, or one smaller than the current head, appears at the head one cycle later. The bench's directed scenarios are needed for the rest. These cover the full read-out order with duplicate words, the choice of which word is lost on an insert into a full array, the dropped insert when both strobes collide, and partial lists of several lengths.

// File: rtl/isort_pkg.sv
package isort_pkg;

    // Occupancy of one slot of the sorting chain
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/isort_ctrl.sv
module isort_ctrl (
    input  logic ins_valid,
    input  logic shift_up,
    output logic ins_en,
    output logic shift_en
);
    // Shift-up has priority: a colliding insert is discarded
    always_comb begin
        shift_en = shift_up;
        ins_en   = ins_valid & ~shift_up;
    end
endmodule

// File: rtl/isort_slot.sv
module isort_slot
    import isort_pkg::*;
#(
    parameter int DATA_WIDTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ins_en,
    input  logic                  shift_en,
    input  logic [DATA_WIDTH-1:0] new_word,
    input  logic                  prev_held,
    input  logic                  prev_push,
    input  logic [DATA_WIDTH-1:0] prev_word,
    input  logic                  next_held,
    input  logic [DATA_WIDTH-1:0] next_word,
    output logic                  held,
    output logic [DATA_WIDTH-1:0] word,
    output logic                  push
);
    typedef struct packed {
        slot_state_e           st;
        logic [DATA_WIDTH-1:0] val;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  fits;
    logic  is_held;

    always_comb begin
        is_held = (slot_q.st == SLOT_HELD);
        fits    = !is_held || (new_word < slot_q.val);
        push    = fits && is_held;

        slot_d = slot_q;
        if (shift_en) begin
            slot_d.val = next_word;
            slot_d.st  = next_held ? SLOT_HELD : SLOT_EMPTY;
        end else if (ins_en) begin
            if (prev_push) begin
                // lower neighbour hands its word up to this slot
                slot_d.val = prev_word;
                slot_d.st  = SLOT_HELD;
            end else if (is_held && fits) begin
                // new word belongs here; own word moves on
                slot_d.val = new_word;
            end else if (!is_held && prev_held) begin
                // first free slot after all smaller words
                slot_d.val = new_word;
                slot_d.st  = SLOT_HELD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.st  <= SLOT_EMPTY;
            slot_q.val <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign held = is_held;
    assign word = slot_q.val;
endmodule

// File: rtl/isort_array.sv
module isort_array
    import isort_pkg::*;
#(
    parameter int DATA_WIDTH = 16,
    parameter int SIZE       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ins_valid,
    input  logic [DATA_WIDTH-1:0] ins_word,
    input  logic                  shift_up,
    output logic [DATA_WIDTH-1:0] head_word,
    output logic                  head_valid,
    output logic [SIZE-1:0]       slot_valid,
    output logic                  full
);
    localparam int FLAT_W = SIZE * DATA_WIDTH;

    logic                  ins_en;
    logic                  shift_en;
    logic                  held_w  [SIZE];
    logic                  push_w  [SIZE];
    logic [DATA_WIDTH-1:0] word_w  [SIZE];
    logic [FLAT_W-1:0]     words_flat;

    isort_ctrl u_ctrl (
        .ins_valid (ins_valid),
        .shift_up  (shift_up),
        .ins_en    (ins_en),
        .shift_en  (shift_en)
    );

    for (genvar i = 0; i < SIZE; i++) begin : g_slot
        logic                  p_held;
        logic                  p_push;
        logic [DATA_WIDTH-1:0] p_word;
        logic                  n_held;
        logic [DATA_WIDTH-1:0] n_word;

        if (i == 0) begin : g_head
            // missing lower neighbour: occupied, never pushing
            assign p_held = 1'b1;
            assign p_push = 1'b0;
            assign p_word = ins_word;
        end else begin : g_body
            assign p_held = held_w[i-1];
            assign p_push = push_w[i-1];
            assign p_word = word_w[i-1];
        end

        if (i == SIZE - 1) begin : g_tail
            assign n_held = 1'b0;
            assign n_word = '0;
        end else begin : g_mid
            assign n_held = held_w[i+1];
            assign n_word = word_w[i+1];
        end

        isort_slot #(.DATA_WIDTH(DATA_WIDTH)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ins_en    (ins_en),
            .shift_en  (shift_en),
            .new_word  (ins_word),
            .prev_held (p_held),
            .prev_push (p_push),
            .prev_word (p_word),
            .next_held (n_held),
            .next_word (n_word),
            .held      (held_w[i]),
            .word      (word_w[i]),
            .push      (push_w[i])
        );

        assign slot_valid[i] = held_w[i];
        assign words_flat[i*DATA_WIDTH +: DATA_WIDTH] = word_w[i];
    end

    assign head_word  = word_w[0];
    assign head_valid = held_w[0];
    assign full       = &slot_valid;
endmodule

// File: rtl/isort_checker.sv
module isort_checker #(
    parameter int DATA_WIDTH = 16,
    parameter int SIZE       = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ins_valid,
    input logic [DATA_WIDTH-1:0]      ins_word,
    input logic                       shift_up,
    input logic [DATA_WIDTH-1:0]      head_word,
    input logic                       head_valid,
    input logic [SIZE-1:0]            slot_valid,
    input logic                       full,
    input logic [SIZE*DATA_WIDTH-1:0] words_flat
);
    // R1 (via reset) and R2: occupancy forms a run starting at the head
    p_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid + 1'b1) & slot_valid) == '0);

    p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !shift_up && !full |=>
        $countones(slot_valid) == $countones($past(slot_valid)) + 1);

    // R3: adjacent occupied slots are ordered
    for (genvar i = 0; i + 1 < SIZE; i++) begin : g_ord
        p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[i+1] |->
            words_flat[i*DATA_WIDTH +: DATA_WIDTH] <= words_flat[(i+1)*DATA_WIDTH +: DATA_WIDTH]);
    end

    p_newmin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !shift_up && head_valid && (ins_word < head_word) |=>
        head_valid && head_word == $past(ins_word));

    // R5: first word is visible at the head one edge later
    p_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !shift_up && !head_valid |=>
        head_valid && head_word == $past(ins_word));

    // R6 / R7: a shift removes exactly one word, whatever ins_valid does
    p_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_up && head_valid |=>
        $countones(slot_valid) + 1 == $countones($past(slot_valid)));

    p_shift_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_up && !head_valid |=> !head_valid);

    // R8: full stays set on an insert into a full array
    p_full_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full && ins_valid && !shift_up |=> full);

    p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> slot_valid[SIZE-1] && head_valid);
endmodule

bind isort_array isort_checker #(.DATA_WIDTH(DATA_WIDTH), .SIZE(SIZE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_word   (ins_word),
    .shift_up   (shift_up),
    .head_word  (head_word),
    .head_valid (head_valid),
    .slot_valid (slot_valid),
    .full       (full),
    .words_flat (words_flat)
);

// File: tb/sim_isort_array.sv
module sim_isort_array;
    localparam int W = 8;
    localparam int S = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ins_valid = 1'b0;
    logic [W-1:0] ins_word = '0;
    logic         shift_up = 1'b0;
    logic [W-1:0] head_word;
    logic         head_valid;
    logic [S-1:0] slot_valid;
    logic         full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    isort_array #(.DATA_WIDTH(W), .SIZE(S)) u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
        .shift_up(shift_up), .head_word(head_word), .head_valid(head_valid),
        .slot_valid(slot_valid), .full(full)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        ins_valid = 1'b0; shift_up = 1'b0; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [W-1:0] w);
        ins_valid = 1'b1; ins_word = w;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic pop();
        shift_up = 1'b1;
        @(negedge clk);
        shift_up = 1'b0;
    endtask

    // read out n words and compare with exp, then expect an empty head
    task automatic drain(input string req, input int n, input int exp[S]);
        for (int k = 0; k < n; k++) begin
            check(req, int'(head_valid), 1);
            check(req, int'(head_word), exp[k]);
            pop();
        end
        check(req, int'(head_valid), 0);
        check(req, int'(slot_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 slot_valid", int'(slot_valid), 0);
        check("R1 head_valid", int'(head_valid), 0);
        check("R1 full", int'(full), 0);
    endtask

    task automatic t_dup_order();
        int e[S] = '{3, 3, 5, 6};
        do_reset();
        put(8'd5);
        check("R5 head after one insert", int'(head_word), 5);
        put(8'd3); put(8'd6); put(8'd3);
        check("R8 full at SIZE words", int'(full), 1);
        drain("R4 R5 R6 duplicate order", 4, e);
    endtask

    task automatic t_partial();
        int e[S] = '{1, 9, 0, 0};
        int f[S] = '{42, 0, 0, 0};
        do_reset();
        put(8'd9); put(8'd1);
        check("R2 occupancy run", int'(slot_valid), 4'b0011);
        check("R8 not full", int'(full), 0);
        drain("R9 two words", 2, e);
        put(8'd42);
        check("R2 single", int'(slot_valid), 4'b0001);
        drain("R9 one word", 1, f);
    endtask

    task automatic t_running_min();
        int e[S] = '{10, 20, 30, 40};
        do_reset();
        put(8'd40); check("R3 min", int'(head_word), 40);
        put(8'd30); check("R3 min", int'(head_word), 30);
        put(8'd20); check("R3 min", int'(head_word), 20);
        check("R2 three held", int'(slot_valid), 4'b0111);
        put(8'd10); check("R3 min", int'(head_word), 10);
        drain("R3 descending input", 4, e);
    endtask

    task automatic t_full_drop();
        int e[S] = '{10, 20, 25, 30};
        do_reset();
        put(8'd10); put(8'd20); put(8'd30); put(8'd40);
        put(8'd25);
        check("R8 still full", int'(full), 1);
        put(8'd99);
        check("R8 larger dropped", int'(slot_valid), 4'b1111);
        drain("R8 keep smallest", 4, e);
    endtask

    task automatic t_collide();
        do_reset();
        put(8'd7);
        ins_valid = 1'b1; ins_word = 8'd2; shift_up = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0; shift_up = 1'b0;
        check("R7 insert dropped", int'(slot_valid), 0);
        check("R7 head empty", int'(head_valid), 0);
        pop();
        check("R6 shift on empty", int'(slot_valid), 0);
    endtask

    task automatic t_lfsr();
        logic [7:0] r = 8'hA5;
        int e[S];
        for (int round = 0; round < 6; round++) begin
            do_reset();
            for (int k = 0; k < S; k++) begin
                r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
                e[k] = int'(r);
                put(r);
            end
            for (int a = 1; a < S; a++)
                for (int b = a; b > 0 && e[b-1] > e[b]; b--) begin
                    int t = e[b]; e[b] = e[b-1]; e[b-1] = t;
                end
            drain("R3 R9 pseudo-random set", S, e);
        end
    endtask

    initial begin
        t_reset();
        t_dup_order();
        t_partial();
        t_running_min();
        t_full_drop();
        t_collide();
        t_lfsr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule